// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Exact Recency Order

This block caches recent page translations for a 16-bit address space split into 256-byte pages. The low eight address bits are the page offset and go through unchanged. The high eight bits are the page number, which is looked up in eight slots. Any page may sit in any slot. A request that hits returns the physical address in the same cycle, together with the slot's modified flag as it stood before the access. On the clock edge that follows, the hit updates that modified flag and the recency order.

A request that misses stalls the requester. The block then moves from state IDLE to state WALK, where it presents the missing page number to an external table walker. When the walker returns the physical page number, the block installs the new translation and goes back to IDLE. The requester has held its request the whole time, so the same request is looked up again and now hits.

Each slot carries a 3-bit recency rank. Rank 0 means most recently used and rank 7 means least recently used, and across the eight slots the ranks always form an exact permutation. A flush pulse, raised whenever the page-table base changes, clears every slot in either state and returns the block to IDLE. The only transitions are IDLE to WALK on a miss, WALK to IDLE when the walker answers, and any state to IDLE on a flush.

Top module: `tlb_lru_xlate`

## Requirements
- R1: On a hit, `rsp_paddr` is the stored physical page number in bits [15:8] and `req_vaddr[7:0]` in bits [7:0]. When there is no hit, `rsp_paddr` reads 0.
- R2: In IDLE, with `req_valid` high and `flush` low, `rsp_valid` is high in the same cycle. `rsp_hit` is high exactly when a valid slot holds `req_vaddr[15:8]`, and a hit leaves `req_stall` low.
- R3: A miss raises `req_stall` and sets `rsp_hit` low in that cycle. From the next cycle, `walk_req` is high with `walk_vpn` equal to the missing page number, and both hold until a cycle in which `walk_valid` or `flush` is high. `walk_vpn` reads 0 in IDLE.
- R4: When the walker answers, the translation goes into the lowest-indexed invalid slot. If no slot is invalid, it goes into the slot of rank 7, and the page that slot held misses afterwards.
- R5: Each hit or install gives the touched slot rank 0. Every slot whose rank was below the touched slot's old rank gains one, and all other ranks stay as they are, so the ranks remain a permutation of 0 to 7.
- R6: `rsp_dirty` on a hit reports the slot's modified flag from before the access. A write hit sets the flag and a read hit leaves it unchanged. An install sets the flag to the write flag of the missing request.
- R7: A cycle with `flush` high holds `rsp_valid` low and `req_stall` high. It invalidates every slot, clears every modified flag, sets slot i to rank i, and returns the block to IDLE, which abandons a pending walk.
- R8: After reset every slot is invalid, the ranks follow slot order, and the block is in IDLE with `walk_req` low.
- R9: At most one valid slot matches any page number.
- R10: A cycle in IDLE with `req_valid` low keeps `req_stall` low and changes no slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all slots (page-table base change) |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 16 | Virtual address |
| req_stall | output | 1 | Requester must hold its request |
| rsp_valid | output | 1 | Lookup result valid this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_dirty | output | 1 | Modified flag of the hit slot before this access |
| rsp_paddr | output | 16 | Translated physical address |
| walk_req | output | 1 | Refill request to the table walker |
| walk_vpn | output | 8 | Page number to be walked |
| walk_valid | input | 1 | Walker result valid |
| walk_ppn | input | 8 | Physical page number from the walker |

## Verification
The assertions assume that the requester holds `req_vaddr` and `req_write` steady while `req_stall` is high. They also assume that the walker answers only while `walk_req` is high and returns a single fixed physical page for each virtual page. Under those two conditions no page can be installed twice, which the one-match property depends on. The stimulus keeps both conditions. It retries each request unchanged until the request is accepted, and it answers each walk after a short random delay with a fixed function of the page number. Flush pulses are injected at random, including in the middle of walks.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 16;
    localparam int OFF_W   = 8;
    localparam int ENTRIES = 8;
    localparam int PN_W    = VA_W - OFF_W;
    localparam int RANK_W  = $clog2(ENTRIES);
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0]           vld,
    input  logic [ENTRIES-1:0][PN_W-1:0] vpn_tab,
    input  logic [PN_W-1:0]              look_vpn,
    output logic [ENTRIES-1:0]           match_v,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_v[g] = vld[g] && (vpn_tab[g] == look_vpn);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_v[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match_v;
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][RANK_W-1:0] rank,
    output logic [IDX_W-1:0]               victim
);
    localparam logic [RANK_W-1:0] RANK_OLDEST = RANK_W'(ENTRIES - 1);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        old_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank[i] == RANK_OLDEST) old_idx = IDX_W'(i);
        end
    end

    assign victim = free_found ? free_idx : old_idx;
endmodule

// File: rtl/tlb_rank_update.sv
module tlb_rank_update
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0][RANK_W-1:0] rank_in,
    input  logic                           touch_en,
    input  logic [IDX_W-1:0]               touch_idx,
    output logic [ENTRIES-1:0][RANK_W-1:0] rank_out
);
    logic [RANK_W-1:0] touched_rank;
    assign touched_rank = rank_in[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        always_comb begin
            rank_out[g] = rank_in[g];
            if (touch_en) begin
                if (touch_idx == IDX_W'(g)) begin
                    rank_out[g] = '0;
                end else if (rank_in[g] < touched_rank) begin
                    rank_out[g] = rank_in[g] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_lru_xlate.sv
module tlb_lru_xlate
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_stall,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_dirty,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             walk_req,
    output logic [PN_W-1:0]  walk_vpn,
    input  logic             walk_valid,
    input  logic [PN_W-1:0]  walk_ppn
);
    tlb_state_e state_q, state_d;

    logic [ENTRIES-1:0]             vld_q;
    logic [ENTRIES-1:0]             dty_q;
    logic [ENTRIES-1:0][PN_W-1:0]   vpn_q;
    logic [ENTRIES-1:0][PN_W-1:0]   ppn_q;
    logic [ENTRIES-1:0][RANK_W-1:0] rank_q;
    logic [ENTRIES-1:0][RANK_W-1:0] rank_d;
    logic [PN_W-1:0]                wvpn_q;
    logic                           wwr_q;

    logic [ENTRIES-1:0] match_v;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    logic               install;
    logic               set_dirty;
    logic               capture;

    tlb_tag_match u_match (
        .vld      (vld_q),
        .vpn_tab  (vpn_q),
        .look_vpn (req_vaddr[VA_W-1:OFF_W]),
        .match_v  (match_v),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    tlb_victim_pick u_victim (
        .vld    (vld_q),
        .rank   (rank_q),
        .victim (victim)
    );

    tlb_rank_update u_rank (
        .rank_in   (rank_q),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .rank_out  (rank_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state, outputs and update strobes
    always_comb begin
        state_d   = state_q;
        req_stall = 1'b0;
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_dirty = 1'b0;
        rsp_paddr = '0;
        walk_req  = 1'b0;
        walk_vpn  = '0;
        touch_en  = 1'b0;
        touch_idx = hit_idx;
        install   = 1'b0;
        set_dirty = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!flush && req_valid) begin
                    rsp_valid = 1'b1;
                    if (hit) begin
                        rsp_hit   = 1'b1;
                        rsp_dirty = dty_q[hit_idx];
                        rsp_paddr = {ppn_q[hit_idx], req_vaddr[OFF_W-1:0]};
                        touch_en  = 1'b1;
                        set_dirty = req_write;
                    end else begin
                        req_stall = 1'b1;
                        capture   = 1'b1;
                        state_d   = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                req_stall = 1'b1;
                walk_req  = 1'b1;
                walk_vpn  = wvpn_q;
                if (!flush && walk_valid) begin
                    install   = 1'b1;
                    touch_en  = 1'b1;
                    touch_idx = victim;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (flush) begin
            state_d   = ST_IDLE;
            req_stall = 1'b1;
            touch_en  = 1'b0;
            install   = 1'b0;
            set_dirty = 1'b0;
            capture   = 1'b0;
        end
    end

    // Slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            dty_q  <= '0;
            vpn_q  <= '0;
            ppn_q  <= '0;
            wvpn_q <= '0;
            wwr_q  <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= RANK_W'(i);
        end else if (flush) begin
            vld_q <= '0;
            dty_q <= '0;
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= RANK_W'(i);
        end else begin
            rank_q <= rank_d;
            if (capture) begin
                wvpn_q <= req_vaddr[VA_W-1:OFF_W];
                wwr_q  <= req_write;
            end
            if (set_dirty) dty_q[hit_idx] <= 1'b1;
            if (install) begin
                vld_q[victim] <= 1'b1;
                dty_q[victim] <= wwr_q;
                vpn_q[victim] <= wvpn_q;
                ppn_q[victim] <= walk_ppn;
            end
        end
    end
endmodule

// File: rtl/tlb_lru_chk.sv
module tlb_lru_chk
    import tlb_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           req_stall,
    input  logic                           rsp_valid,
    input  logic                           rsp_hit,
    input  logic                           walk_req,
    input  logic [PN_W-1:0]                walk_vpn,
    input  logic                           walk_valid,
    input  logic [ENTRIES-1:0]             match_v,
    input  logic [ENTRIES-1:0]             vld_q,
    input  logic [ENTRIES-1:0][RANK_W-1:0] rank_q
);
    logic [ENTRIES-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < ENTRIES; i++) rank_seen[rank_q[i]] = 1'b1;
    end

    assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rank_seen == '1);

    assert_one_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_v));

    assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && !req_stall));

    assert_miss_walks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> req_stall ##1 walk_req);

    assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_valid && !flush) |=> (walk_req && $stable(walk_vpn)));

    assert_fill_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_valid && !flush && !(&vld_q)) |=>
        (!walk_req && ($countones(vld_q) == $past($countones(vld_q)) + 1)));

    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0 && !walk_req));

    assert_reset_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld_q == '0 && !walk_req));
endmodule

bind tlb_lru_xlate tlb_lru_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_stall  (req_stall),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .walk_valid (walk_valid),
    .match_v    (match_v),
    .vld_q      (vld_q),
    .rank_q     (rank_q)
);

// File: tb/tb_tlb_lru_xlate.sv
`timescale 1ns/1ps
module tb_tlb_lru_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        req_stall, rsp_valid, rsp_hit, rsp_dirty, walk_req;
    logic [15:0] rsp_paddr;
    logic [7:0]  walk_vpn;
    logic        walk_valid = 1'b0;
    logic [7:0]  walk_ppn = '0;

    always #2 clk = ~clk;

    tlb_lru_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_write(req_write), .req_vaddr(req_vaddr), .req_stall(req_stall),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
        .rsp_paddr(rsp_paddr), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_valid(walk_valid), .walk_ppn(walk_ppn)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference
    int m_valid[8];
    int m_dirty[8];
    int m_vpn[8];
    int m_ppn[8];
    int order[$];
    bit m_walk;
    int m_wvpn;
    bit m_wwr;
    bit last_accepted;
    int flush_rate = 0;
    string phase = "R8 reset";

    function automatic void model_clear();
        for (int s = 0; s < 8; s++) begin
            m_valid[s] = 0;
            m_dirty[s] = 0;
        end
        order.delete();
        for (int s = 0; s < 8; s++) order.push_back(s);
        m_walk = 0;
    endfunction

    function automatic void touch(int s);
        for (int k = 0; k < order.size(); k++) begin
            if (order[k] == s) begin
                order.delete(k);
                break;
            end
        end
        order.push_front(s);
    endfunction

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    function automatic int ppn_of(int vpn);
        return (vpn ^ 8'hA5) & 8'hFF;
    endfunction

    task automatic step(input bit rv, input bit wr, input logic [15:0] va,
                        input bit wv, input logic [7:0] wp, input bit fl);
        int hs;
        bit e_valid, e_hit, e_stall;
        int e_pa, e_dty, e_wvpn;
        int victim;
        @(negedge clk);
        req_valid  = rv;
        req_write  = wr;
        req_vaddr  = va;
        walk_valid = wv;
        walk_ppn   = wp;
        flush      = fl;
        #1;
        hs = -1;
        for (int s = 0; s < 8; s++)
            if (m_valid[s] != 0 && m_vpn[s] == int'(va[15:8])) hs = s;
        e_valid = !fl && !m_walk && rv;
        e_hit   = e_valid && (hs >= 0);
        e_pa    = e_hit ? ((m_ppn[hs] << 8) | int'(va[7:0])) : 0;
        e_dty   = e_hit ? m_dirty[hs] : 0;
        e_stall = fl || m_walk || (rv && hs < 0);
        e_wvpn  = m_walk ? m_wvpn : 0;
        chk("R2 rsp_valid", rsp_valid, e_valid);
        chk("R2/R4/R5 rsp_hit", rsp_hit, e_hit);
        chk("R1 rsp_paddr", rsp_paddr, e_pa);
        chk("R6 rsp_dirty", rsp_dirty, e_dty);
        chk("R3/R7/R10 req_stall", req_stall, e_stall);
        chk("R3 walk_req", walk_req, m_walk);
        chk("R3 walk_vpn", walk_vpn, e_wvpn);
        last_accepted = rv && !e_stall;
        // state as after the coming edge
        if (fl) begin
            model_clear();
        end else if (m_walk) begin
            if (wv) begin
                victim = -1;
                for (int s = 7; s >= 0; s--) if (m_valid[s] == 0) victim = s;
                if (victim < 0) victim = order[7];
                m_valid[victim] = 1;
                m_dirty[victim] = m_wwr;
                m_vpn[victim]   = m_wvpn;
                m_ppn[victim]   = int'(wp);
                touch(victim);
                m_walk = 0;
            end
        end else if (rv) begin
            if (hs >= 0) begin
                if (wr) m_dirty[hs] = 1;
                touch(hs);
            end else begin
                m_walk = 1;
                m_wvpn = int'(va[15:8]);
                m_wwr  = wr;
            end
        end
    endtask

    task automatic access(input int vpn, input int off, input bit wr);
        int guard = 0;
        int wcnt = 1;
        bit done = 0;
        while (!done && guard < 60) begin
            bit fl;
            bit wv;
            fl = (flush_rate != 0) && ($urandom % flush_rate == 0);
            wv = m_walk && (wcnt == 0);
            if (m_walk && wcnt > 0) wcnt--;
            else if (!m_walk) wcnt = $urandom % 3;
            step(1'b1, wr, 16'((vpn << 8) | off), wv,
                 m_walk ? 8'(ppn_of(m_wvpn)) : 8'h3C, fl);
            done = last_accepted;
            guard++;
        end
        if (!done) chk("R3 access completes", 0, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h5A5A, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: empty after reset, no request
        phase = "R8 reset";
        idle(2);
        // R2 R3 R4: fill free slots in index order, read/write mix
        phase = "R4 fill";
        access(8'h01, 8'h10, 1);
        access(8'h10, 8'h22, 1);
        access(8'h20, 8'h30, 0);
        access(8'h11, 8'h44, 0);
        access(8'hAC, 8'h55, 1);
        access(8'hFF, 8'h66, 0);
        // R1 R6: offsets pass through, dirty reports prior value
        phase = "R6 dirty";
        access(8'h11, 8'hF0, 0);
        access(8'h20, 8'hAE, 1);
        access(8'h20, 8'hFF, 0);
        access(8'h11, 8'h00, 0);
        // R10: idle cycles change nothing
        phase = "R10 idle";
        idle(4);
        // R4 R5: overflow into rank-7 victims
        phase = "R5 evict";
        access(8'h13, 8'h01, 1);
        access(8'h23, 8'h32, 1);
        access(8'h34, 8'h15, 1);
        access(8'h01, 8'h02, 0);
        access(8'h10, 8'h03, 0);
        access(8'h99, 8'h04, 0);
        // R7: flush mid-walk and when idle
        phase = "R7 flush";
        step(1'b1, 1'b0, 16'h7711, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b0, 16'h7711, 1'b0, 8'h00, 1'b1);
        access(8'h77, 8'h11, 0);
        step(1'b1, 1'b1, 16'h7712, 1'b0, 8'h00, 1'b1);
        access(8'h01, 8'h00, 0);
        // R9 and all: random traffic over a 12-page pool
        phase = "R9 random";
        flush_rate = 150;
        for (int i = 0; i < 1500; i++) begin
            if ($urandom % 5 == 0) idle(1);
            else access(((($urandom % 12) * 8'h13) + 1) & 8'hFF, $urandom % 256, $urandom % 2);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule